// File: doc/BRIEF.md
# Clock Generator Configuration Slave on a Two-Wire Bus

This block is the serial control port of a multi-output clock generator. It holds a bank of eight byte-wide configuration registers and exposes all of them as one flat parallel bus, so the synthesis and gating logic next to it can decode enable bits and frequency selects directly. A host reaches the bank over a two-wire serial bus (SCL and SDA). The slave drives SDA only by pulling it low, through an open-drain enable.

A write transfer always has the same shape. The host sends the device address with the write bit, then two header bytes, then the data. The slave acknowledges both header bytes and discards their values. It has no register pointer. The first data byte always lands in register 0, and each later byte goes to the next register. A read transfer also starts at register 0. The slave returns one register after another until the host answers a byte with NACK.

Registers 0 to 5 are writable. Registers 6 and 7 are fixed identification bytes. A power-up reset is the only thing that restores the register defaults. A START or STOP condition on the bus leaves the register contents unchanged.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: While `por_n` is low and after it rises, `cfg_o` shows the defaults: register 0 = 0x00, 1 = 0x1D, 2 = 0xFF, 3 = 0xFF, 4 = 0xEB, 5 = 0x9F, 6 = 0x98, 7 = 0x51.
- R2: If the 7-bit address in the first byte after START is not `DEV_ADDR` (default 0x69), the slave does not acknowledge it, and no register changes for the rest of that transfer.
- R3: After its own address with the R/W bit at 0 (write), the slave acknowledges the next two bytes (command and byte count) and writes neither of them to any register.
- R4: Data bytes that follow the two header bytes are written to register 0, 1, 2 and onward in order, and each one is acknowledged.
- R5: Data bytes addressed to register 6, to register 7, or beyond the last register are acknowledged and discarded. The index saturates, so register 0 is never overwritten a second time within the same transfer.
- R6: After its own address with the R/W bit at 1 (read), the slave sends register 0 first, MSB first, then each following register for as long as the host acknowledges. Positions past register 7 read 0xFF. After a NACK from the host the slave releases SDA.
- R7: A START or STOP anywhere ends the current transfer. A partly received byte is dropped. A repeated START begins a new address phase, in which the header count and the register index start again from zero.
- R8: Only `por_n` changes register contents outside a completed data byte. Bus conditions such as STOP do not restore the defaults.
- R9: The slave changes `sda_oe` only while SCL is low, except when it releases SDA because of a START or STOP.
- R10: Register i appears on `cfg_o[8*i+7 : 8*i]`. In registers 2, 3 and 5, an enable bit set to 1 marks the corresponding clock output as active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| por_n | input | 1 | Asynchronous active-low true power-up reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_o | output | 64 | All eight registers, register i in byte i |

## Verification
The assertions assume a bus that follows the two-wire rules. SDA changes while SCL is high only to form a START or a STOP, and each SCL level lasts several system clocks, so the two-flop synchronizers always see clean, separate edges. The bench's bus master keeps every SCL phase 16 clocks long. It moves SDA only in the middle of the SCL-low phase and models the line as a wired AND of its own drive and the slave's pull-down. A bench monitor watches for the slave moving SDA while SCL is high.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NUM_RW   = 6;
  localparam int NUM_RO   = 2;
  localparam int NUM_REGS = NUM_RW + NUM_RO;
  localparam int IDX_W    = $clog2(NUM_REGS + 1);
  localparam int NUM_HDR  = 2;
  localparam int HDR_W    = $clog2(NUM_HDR + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_WR, ST_ACK_W, ST_RD, ST_RACK
  } bus_st_e;

  function automatic logic [7:0] rw_default(input int idx);
    case (idx)
      1:       rw_default = 8'h1D;
      2:       rw_default = 8'hFF;
      3:       rw_default = 8'hFF;
      4:       rw_default = 8'hEB;
      5:       rw_default = 8'h9F;
      default: rw_default = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/clkcfg_bus_fsm.sv
module clkcfg_bus_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_idx
);
  bus_st_e          state;
  logic [7:0]       sh;
  logic [3:0]       bitcnt;
  logic [HDR_W-1:0] hdr;
  logic [IDX_W-1:0] idx;
  logic             rd_mode;
  logic             mack;

  assign rd_idx = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sh      <= '0;
      bitcnt  <= '0;
      hdr     <= '0;
      idx     <= '0;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        hdr    <= '0;
        idx    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  state   <= ST_ACK_A;
                  sda_oe  <= 1'b1;
                  rd_mode <= sh[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state  <= ST_ACK_W;
                sda_oe <= 1'b1;
                if (hdr != HDR_W'(NUM_HDR)) begin
                  hdr <= hdr + 1'b1;
                end else begin
                  if (idx < IDX_W'(NUM_RW)) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= idx;
                    wr_data <= sh;
                  end
                  if (idx < IDX_W'(NUM_REGS)) idx <= idx + 1'b1;
                end
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              if (rd_mode) begin
                state  <= ST_RD;
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                state  <= ST_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_ACK_W: begin
            if (scl_fall) begin
              state  <= ST_WR;
              sda_oe <= 1'b0;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (!sda_s && idx < IDX_W'(NUM_REGS)) idx <= idx + 1'b1;
            end else if (scl_fall) begin
              if (mack) begin
                state  <= ST_RD;
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: START always opens a fresh address phase
  assert_start_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR));

  // R7: STOP returns to idle with SDA released
  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_oe));

  // R3: bytes still in the header never reach the register bank
  assert_hdr_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr != HDR_W'(NUM_HDR)) |=> !wr_en);

  // R9: SDA drive is steady while SCL stays high, unless START/STOP intervened
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe));
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter logic [7:0] ID_HI = 8'h98,
  parameter logic [7:0] ID_LO = 8'h51
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  logic [7:0] rw_q [NUM_RW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RW; i++) rw_q[i] <= rw_default(i);
    end else if (wr_en) begin
      for (int i = 0; i < NUM_RW; i++)
        if (wr_idx == IDX_W'(i)) rw_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_RW; i++)
      if (rd_idx == IDX_W'(i)) rd_data = rw_q[i];
    if (rd_idx == IDX_W'(NUM_REGS - 2)) rd_data = ID_HI;
    if (rd_idx == IDX_W'(NUM_REGS - 1)) rd_data = ID_LO;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    if (g < NUM_RW) begin : g_rw
      assign regs_flat[g*8 +: 8] = rw_q[g];
    end else if (g == NUM_REGS - 2) begin : g_idhi
      assign regs_flat[g*8 +: 8] = ID_HI;
    end else begin : g_idlo
      assign regs_flat[g*8 +: 8] = ID_LO;
    end
  end

  // R5: the bus side only ever targets a writable register
  assert_wr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(NUM_RW)));

  // R8: without a write strobe the bank holds its contents
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] ID_HI       = 8'h98,
  parameter logic [7:0] ID_LO       = 8'h51,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  clkcfg_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(por_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(rd_data),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx)
  );

  clkcfg_regbank #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_bank (
    .clk(clk), .rst_n(por_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .regs_flat(cfg_o)
  );
endmodule

// File: tb/clkcfg_i2c_slave_bench.sv
module clkcfg_i2c_slave_bench;
  localparam int Q = 16;
  localparam logic [6:0] ADDR = 7'h69;
  localparam logic [63:0] DEFAULTS = 64'h5198_9FEB_FFFF_1D00;
  localparam int NVEC = 4;
  localparam logic [47:0] VEC [NVEC] = '{
    48'hFFFF_FFFF_FFFF, 48'h0000_0000_0000,
    48'hA55A_C33C_0FF0, 48'h1234_5678_9ABC };

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [63:0] cfg_o;
  wire  sda_bus = sda_m & ~sda_oe;

  int total = 0;
  int bad = 0;
  int r9_viol = 0;

  always #10 clk = ~clk;

  clkcfg_i2c_slave u_clkcfg_i2c_slave (
    .clk(clk), .por_n(por_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  // R9 monitor: slave pull-down must not move while SCL is high
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  always @(negedge clk) begin
    if (por_n && scl_m && scl_prev && (sda_oe != oe_prev)) r9_viol++;
    oe_prev  <= sda_oe;
    scl_prev <= scl_m;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wq(Q/2); sda_m = 1'b1; wq(Q/2); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(Q/2); sda_m = 1'b0; wq(Q/2); scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wq(Q/2); sda_m = b[i]; wq(Q/2); scl_m = 1'b1; wq(Q); scl_m = 1'b0;
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    wq(Q/2); sda_m = 1'b1; wq(Q/2); scl_m = 1'b1; wq(Q/2);
    acked = ~sda_bus;
    wq(Q/2); scl_m = 1'b0;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(Q/2); sda_m = 1'b1; wq(Q/2); scl_m = 1'b1; wq(Q/2);
      b[i] = sda_bus;
      wq(Q/2); scl_m = 1'b0;
    end
    wq(Q/2); sda_m = ~ack; wq(Q/2); scl_m = 1'b1; wq(Q); scl_m = 1'b0;
  endtask

  // full block write: address, two header bytes, n data bytes; returns AND of acks
  task automatic blk_write(input logic [6:0] a, input logic [79:0] data, input int n,
                           output logic all_ack);
    logic k;
    bus_start();
    wr_byte({a, 1'b0}, k); all_ack = k;
    wr_byte(8'hA5, k); all_ack &= k;
    wr_byte(8'h3C, k); all_ack &= k;
    for (int i = 0; i < n; i++) begin
      wr_byte(data[i*8 +: 8], k); all_ack &= k;
    end
    bus_stop();
  endtask

  task automatic blk_read(input int n, output logic [79:0] data, output logic a_ack);
    logic [7:0] b;
    data = '0;
    bus_start();
    wr_byte({ADDR, 1'b1}, a_ack);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, b);
      data[i*8 +: 8] = b;
    end
    bus_stop();
  endtask

  initial begin
    logic ok;
    logic [79:0] rd;
    logic [63:0] snap;
    wq(5);
    chk("R1 defaults during reset", cfg_o, DEFAULTS);
    por_n = 1'b1;
    wq(5);
    chk("R1 R10 defaults after reset", cfg_o, DEFAULTS);
    chk("R9 idle no drive", {63'd0, sda_oe}, 64'd0);

    // vector table: write six registers, check parallel view and read-back
    for (int v = 0; v < NVEC; v++) begin
      blk_write(ADDR, {32'd0, VEC[v]}, 6, ok);
      chk("R3 R4 all bytes acked", {63'd0, ok}, 64'd1);
      chk("R4 R10 registers in order", cfg_o, {16'h5198, VEC[v]});
      blk_read(8, rd, ok);
      chk("R6 read address acked", {63'd0, ok}, 64'd1);
      chk("R6 read-back from register 0", rd[63:0], {16'h5198, VEC[v]});
      chk("R6 released after NACK", {63'd0, sda_oe}, 64'd0);
    end

    // R2: foreign address
    snap = cfg_o;
    blk_write(7'h22, 80'h0102030405, 5, ok);
    chk("R2 foreign address not acked", {63'd0, ok}, 64'd0);
    chk("R2 registers unchanged", cfg_o, snap);

    // R7: STOP in the middle of a data byte drops it
    bus_start();
    wr_byte({ADDR, 1'b0}, ok); wr_byte(8'h00, ok); wr_byte(8'h00, ok);
    wr_byte(8'h11, ok);
    send_bits(8'hEE, 4);
    bus_stop();
    chk("R7 partial byte dropped", cfg_o, {snap[63:8], 8'h11});

    // R7: repeated START during header restarts the header count
    bus_start();
    wr_byte({ADDR, 1'b0}, ok); wr_byte(8'h77, ok);
    bus_start();
    wr_byte({ADDR, 1'b0}, ok); wr_byte(8'h00, ok); wr_byte(8'h00, ok);
    wr_byte(8'h22, ok);
    bus_start();
    wr_byte({ADDR, 1'b1}, ok);
    rd_byte(1'b0, rd[7:0]);
    bus_stop();
    chk("R7 repeated start restarts header and index", {56'd0, rd[7:0]}, 64'h22);
    chk("R7 R3 header byte not stored", cfg_o, {snap[63:8], 8'h22});

    // R5: write past the writable range, index saturates
    blk_write(ADDR, 80'h39_38_37_36_35_34_33_32_31_30, 10, ok);
    chk("R5 surplus bytes acked", {63'd0, ok}, 64'd1);
    chk("R5 no wrap, RO intact", cfg_o, 64'h5198_3534_3332_3130);
    blk_read(10, rd, ok);
    chk("R6 read past end gives FF", rd, 80'hFFFF_5198_3534_3332_3130);

    // R8: bus activity never restores defaults, power-up reset does
    bus_start(); bus_stop();
    chk("R8 STOP keeps contents", cfg_o, 64'h5198_3534_3332_3130);
    por_n = 1'b0; wq(3);
    por_n = 1'b1; wq(3);
    chk("R8 R1 power-up restores defaults", cfg_o, DEFAULTS);

    chk("R9 SDA steady while SCL high", 64'(r9_viol), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule